// File: doc/BRIEF.md
# Saturating 16x16 Multiply-Accumulate Unit

This block multiplies two 16-bit operands every clock and folds the product into a 40-bit signed accumulator. The 40-bit width gives eight guard bits above the 32-bit product field. Each operand pair comes with a valid strobe and its own control bits. The format bit selects signed or unsigned operands. The operation field selects load, add, subtract or hold. Further bits select rounding, saturation and the width of the extracted result.

The pipeline has two register stages. The first stage registers the product, already extended to 40 bits. The second stage holds the new accumulator and a 32-bit result taken from that new value, either as a 32-bit word or as a 16-bit half-word that is sign-extended. The block takes a new operand pair on every cycle, so it suits streaming dot products and filter taps. A sticky overflow flag records saturation events until the next load.

Top module: `mac16_unit`

## Requirements
- R1: One operand pair is accepted per cycle. Its result is shown on `acc_out`, `res_out` and `ovf_sticky`, with `out_valid` high, two clock edges after the edge that samples `in_valid`. Back-to-back pairs give back-to-back results.
- R2: With `is_signed`=1 both operands are two's complement. With `is_signed`=0 both are unsigned and the 32-bit product is zero-extended to 40 bits.
- R3: `op_sel` encoding: 2'b00 loads the product into the accumulator, 2'b01 adds it, 2'b10 subtracts it, and 2'b11 holds the accumulator while still producing a result.
- R4: A cycle with `in_valid`=0 leaves `acc_out`, `res_out` and `ovf_sticky` unchanged, and `out_valid` is low two edges later.
- R5: The accumulator is a signed 40-bit value. With `sat_en`=0 an overflow wraps modulo 2^40 and leaves `ovf_sticky` unchanged.
- R6: With `sat_en`=1 an overflow clamps the accumulator to 40'h7F_FFFF_FFFF or 40'h80_0000_0000 and sets `ovf_sticky`.
- R7: `ovf_sticky` is cleared only by a load operation. Hold, add and subtract never clear it.
- R8: With `half_sel`=0, `res_out` is bits [31:0] of the accumulator. With `sat_en`=1 it is instead clamped to 32'h7FFF_FFFF or 32'h8000_0000 when the accumulator is outside the signed 32-bit range. `rnd_en` has no effect in this mode.
- R9: With `half_sel`=1, `res_out` is accumulator bits [31:16], sign-extended to 32 bits. With `rnd_en`=1, 0x8000 is added to the accumulator first (round half up).
- R10: With `half_sel`=1 and `sat_en`=1, a rounded value outside the signed 16-bit range gives 32'h0000_7FFF or 32'hFFFF_8000.
- R11: After reset `acc_out`, `res_out`, `ovf_sticky` and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair and controls are valid |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| is_signed | input | 1 | 1: two's complement operands, 0: unsigned |
| op_sel | input | 2 | 00 load, 01 add, 10 subtract, 11 hold |
| rnd_en | input | 1 | Round half up on 16-bit extraction |
| sat_en | input | 1 | Saturate the accumulator and the extraction |
| half_sel | input | 1 | 1: 16-bit result, 0: 32-bit result |
| out_valid | output | 1 | Result from the operand pair two edges earlier |
| acc_out | output | 40 | Accumulator contents |
| res_out | output | 32 | Extracted result |
| ovf_sticky | output | 1 | Sticky saturation flag |

## Verification
A wrong accumulator value shows on `acc_out` in the very cycle that `out_valid` rises for the pair that caused it. It also shows on every later result, because each add builds on the previous value. This makes a single wrong extension or sign bit visible within two cycles. Overflow faults need long runs of maximum-size products, about 130 in a row, before the accumulator reaches its 40-bit limit. A wrong clamp or flag is only visible after that run, and a wrongly cleared flag is only visible after a later hold or idle cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_LOAD = 2'b00,
        OP_ADD  = 2'b01,
        OP_SUB  = 2'b10,
        OP_HOLD = 2'b11
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int A_W   = 16,
    parameter int ACC_W = 40
) (
    input  logic [A_W-1:0]   a_in,
    input  logic [A_W-1:0]   b_in,
    input  logic             sgn,
    output logic [ACC_W-1:0] prod_ext
);
    localparam int MUL_W = 2 * A_W + 2;
    localparam int EXT_W = ACC_W - MUL_W;

    logic signed [A_W:0]   a_x;
    logic signed [A_W:0]   b_x;
    logic signed [MUL_W-1:0] prod;

    always_comb begin
        a_x      = $signed({a_in[A_W-1] & sgn, a_in});
        b_x      = $signed({b_in[A_W-1] & sgn, b_in});
        prod     = a_x * b_x;
        prod_ext = {{EXT_W{prod[MUL_W-1]}}, prod};
    end
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACC_W = 40
) (
    input  logic [ACC_W-1:0] acc_cur,
    input  logic [ACC_W-1:0] prod,
    input  mac_op_e          op,
    input  logic             sat,
    output logic [ACC_W-1:0] acc_nx,
    output logic             ovf_evt
);
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0] a_w;
    logic [ACC_W:0] p_w;
    logic [ACC_W:0] sum;

    always_comb begin
        a_w = {acc_cur[ACC_W-1], acc_cur};
        p_w = {prod[ACC_W-1], prod};
        unique case (op)
            OP_LOAD: sum = p_w;
            OP_ADD:  sum = a_w + p_w;
            OP_SUB:  sum = a_w - p_w;
            default: sum = a_w;
        endcase
        ovf_evt = sum[ACC_W] ^ sum[ACC_W-1];
        if (ovf_evt && sat)
            acc_nx = sum[ACC_W] ? ACC_MIN : ACC_MAX;
        else
            acc_nx = sum[ACC_W-1:0];
    end
endmodule

// File: rtl/mac_extract.sv
module mac_extract #(
    parameter int ACC_W  = 40,
    parameter int RES_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic [ACC_W-1:0] acc,
    input  logic             rnd,
    input  logic             sat,
    input  logic             half,
    output logic [RES_W-1:0] res
);
    localparam int SH_W = ACC_W + 1 - HALF_W;
    localparam logic [ACC_W:0] RND_K = (ACC_W+1)'(1) << (HALF_W - 1);

    logic [ACC_W:0]      rnd_sum;
    logic [SH_W-1:0]     sh;
    logic [HALF_W-1:0]   r16;
    logic [RES_W-1:0]    r32;
    logic                fit16;
    logic                fit32;

    always_comb begin
        rnd_sum = {acc[ACC_W-1], acc} + (rnd ? RND_K : '0);
        sh      = rnd_sum[ACC_W:HALF_W];
        fit16   = (sh[SH_W-1:HALF_W-1] == '0) || (sh[SH_W-1:HALF_W-1] == '1);
        if (sat && !fit16)
            r16 = sh[SH_W-1] ? {1'b1, {(HALF_W-1){1'b0}}} : {1'b0, {(HALF_W-1){1'b1}}};
        else
            r16 = sh[HALF_W-1:0];

        fit32 = (acc[ACC_W-1:RES_W-1] == '0) || (acc[ACC_W-1:RES_W-1] == '1);
        if (sat && !fit32)
            r32 = acc[ACC_W-1] ? {1'b1, {(RES_W-1){1'b0}}} : {1'b0, {(RES_W-1){1'b1}}};
        else
            r32 = acc[RES_W-1:0];

        res = half ? {{(RES_W-HALF_W){r16[HALF_W-1]}}, r16} : r32;
    end
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
    import mac_pkg::*;
#(
    parameter int A_W    = 16,
    parameter int ACC_W  = 40,
    parameter int RES_W  = 32,
    parameter int HALF_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [A_W-1:0]   op_a,
    input  logic [A_W-1:0]   op_b,
    input  logic             is_signed,
    input  logic [1:0]       op_sel,
    input  logic             rnd_en,
    input  logic             sat_en,
    input  logic             half_sel,
    output logic             out_valid,
    output logic [ACC_W-1:0] acc_out,
    output logic [RES_W-1:0] res_out,
    output logic             ovf_sticky
);
    typedef struct packed {
        logic             vld1;
        logic [ACC_W-1:0] prod1;
        mac_op_e          op1;
        logic             sat1;
        logic             rnd1;
        logic             half1;
        logic             vld2;
        logic [ACC_W-1:0] acc;
        logic [RES_W-1:0] res;
        logic             ovf;
    } st_t;

    st_t st_d, st_q;

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_nx;
    logic             ovf_evt;
    logic [RES_W-1:0] res_nx;

    mac_mult #(.A_W(A_W), .ACC_W(ACC_W)) u_mult (
        .a_in     (op_a),
        .b_in     (op_b),
        .sgn      (is_signed),
        .prod_ext (prod_ext)
    );

    mac_accum #(.ACC_W(ACC_W)) u_accum (
        .acc_cur (st_q.acc),
        .prod    (st_q.prod1),
        .op      (st_q.op1),
        .sat     (st_q.sat1),
        .acc_nx  (acc_nx),
        .ovf_evt (ovf_evt)
    );

    mac_extract #(.ACC_W(ACC_W), .RES_W(RES_W), .HALF_W(HALF_W)) u_extract (
        .acc  (acc_nx),
        .rnd  (st_q.rnd1),
        .sat  (st_q.sat1),
        .half (st_q.half1),
        .res  (res_nx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld1 = in_valid;
        if (in_valid) begin
            st_d.prod1 = prod_ext;
            st_d.op1   = mac_op_e'(op_sel);
            st_d.sat1  = sat_en;
            st_d.rnd1  = rnd_en;
            st_d.half1 = half_sel;
        end
        st_d.vld2 = st_q.vld1;
        if (st_q.vld1) begin
            st_d.acc = acc_nx;
            st_d.res = res_nx;
            if (st_q.op1 == OP_LOAD)
                st_d.ovf = 1'b0;
            else
                st_d.ovf = st_q.ovf | (ovf_evt & st_q.sat1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid  = st_q.vld2;
    assign acc_out    = st_q.acc;
    assign res_out    = st_q.res;
    assign ovf_sticky = st_q.ovf;

    AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid, 2) == out_valid); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.vld1 |=> ($stable(acc_out) && $stable(res_out) && $stable(ovf_sticky))); // R4

    AST_FLAG_NEEDS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sticky) |-> $past(st_q.sat1)); // R6

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld1 && st_q.op1 == OP_LOAD) |=> !ovf_sticky); // R7

    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !(st_q.vld1 && st_q.op1 == OP_LOAD)) |=> ovf_sticky); // R7

    AST_HALF_SIGNEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld1 && st_q.half1) |=>
            (res_out[RES_W-1:HALF_W-1] == '0 || res_out[RES_W-1:HALF_W-1] == '1)); // R9

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.vld1 && st_q.op1 == OP_HOLD) |=> $stable(acc_out)); // R3
endmodule

// File: tb/tb_mac16_unit.sv
module tb_mac16_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NTAB = 11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        is_signed = 1'b0;
    logic [1:0]  op_sel = '0;
    logic        rnd_en = 1'b0;
    logic        sat_en = 1'b0;
    logic        half_sel = 1'b0;
    logic        out_valid;
    logic [39:0] acc_out;
    logic [31:0] res_out;
    logic        ovf_sticky;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac16_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .is_signed(is_signed), .op_sel(op_sel), .rnd_en(rnd_en), .sat_en(sat_en),
        .half_sel(half_sel), .out_valid(out_valid), .acc_out(acc_out),
        .res_out(res_out), .ovf_sticky(ovf_sticky)
    );

    // op, a, b, signed, rnd, sat, half, expected acc, expected res
    typedef struct packed {
        logic [1:0]  op;
        logic [15:0] a;
        logic [15:0] b;
        logic        sgn;
        logic        rnd;
        logic        sat;
        logic        half;
        logic [39:0] e_acc;
        logic [31:0] e_res;
    } vec_t;

    localparam vec_t TAB [NTAB] = '{
        '{2'b00, 16'd3,    16'd4,    1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0000_000C, 32'h0000_000C},
        '{2'b01, 16'hFFFE, 16'd5,    1'b1, 1'b0, 1'b0, 1'b0, 40'h00_0000_0002, 32'h0000_0002},
        '{2'b10, 16'd7,    16'd7,    1'b1, 1'b0, 1'b0, 1'b0, 40'hFF_FFFF_FFD1, 32'hFFFF_FFD1},
        '{2'b00, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, 40'h00_FFFE_0001, 32'h7FFF_FFFF},
        '{2'b01, 16'h4000, 16'h4000, 1'b1, 1'b0, 1'b0, 1'b1, 40'h01_0FFE_0001, 32'h0000_0FFE},
        '{2'b11, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b1, 1'b1, 40'h01_0FFE_0001, 32'h0000_7FFF},
        '{2'b00, 16'd1,    16'h8000, 1'b1, 1'b1, 1'b1, 1'b1, 40'hFF_FFFF_8000, 32'h0000_0000},
        '{2'b00, 16'd3,    16'h4000, 1'b1, 1'b1, 1'b1, 1'b1, 40'h00_0000_C000, 32'h0000_0001},
        '{2'b00, 16'h8000, 16'h8000, 1'b1, 1'b0, 1'b1, 1'b1, 40'h00_4000_0000, 32'h0000_4000},
        '{2'b00, 16'h8000, 16'h7FFF, 1'b1, 1'b0, 1'b1, 1'b1, 40'hFF_C000_8000, 32'hFFFF_C000},
        '{2'b00, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, 40'h00_FFFE_0001, 32'hFFFE_0001}
    };

    // reference model state
    longint      m_acc = 0;
    logic        m_ovf = 1'b0;
    logic [31:0] m_res = '0;

    typedef struct {
        logic        v;
        logic [39:0] acc;
        logic [31:0] res;
        logic        ovf;
        string       tag;
    } exp_t;

    exp_t pipe0 = '{1'b0, 40'h0, 32'h0, 1'b0, "R4"};
    exp_t pipe1 = '{1'b0, 40'h0, 32'h0, 1'b0, "R4"};

    task automatic chk(input string tag, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic model(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic sgn, input logic rnd, input logic sat, input logic half);
        longint p, s, v;
        p = sgn ? longint'($signed(a)) * longint'($signed(b))
                : longint'({48'h0, a}) * longint'({48'h0, b});
        case (op)
            2'b00:   s = p;
            2'b01:   s = m_acc + p;
            2'b10:   s = m_acc - p;
            default: s = m_acc;
        endcase
        if (op == 2'b00) m_ovf = 1'b0;
        if (s > 64'sh7F_FFFF_FFFF || s < -64'sh80_0000_0000) begin
            if (sat) begin
                m_ovf = 1'b1;
                s = (s > 0) ? 64'sh7F_FFFF_FFFF : -64'sh80_0000_0000;
            end else begin
                s = (s <<< 24) >>> 24;
            end
        end
        m_acc = s;
        if (half) begin
            v = (m_acc + (rnd ? 64'sd32768 : 64'sd0)) >>> 16;
            if (sat && v > 32767)       v = 32767;
            else if (sat && v < -32768) v = -32768;
            else                        v = longint'($signed(v[15:0]));
        end else begin
            v = m_acc;
            if (sat && v > 64'sh7FFF_FFFF)       v = 64'sh7FFF_FFFF;
            else if (sat && v < -64'sh8000_0000) v = -64'sh8000_0000;
        end
        m_res = v[31:0];
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [15:0] a,
                        input logic [15:0] b, input logic sgn, input logic rnd,
                        input logic sat, input logic half, input logic use_tab,
                        input logic [39:0] t_acc, input logic [31:0] t_res,
                        input string tag);
        exp_t e;
        @(negedge clk);
        chk(pipe1.tag, "out_valid", 64'(out_valid), 64'(pipe1.v));
        chk(pipe1.tag, "acc_out", 64'(acc_out), 64'(pipe1.acc));
        chk(pipe1.tag, "res_out", 64'(res_out), 64'(pipe1.res));
        chk(pipe1.tag, "ovf_sticky", 64'(ovf_sticky), 64'(pipe1.ovf));
        pipe1 = pipe0;
        if (v) model(op, a, b, sgn, rnd, sat, half);
        e.v   = v;
        e.acc = use_tab ? t_acc : m_acc[39:0];
        e.res = use_tab ? t_res : m_res;
        e.ovf = m_ovf;
        e.tag = tag;
        pipe0 = e;
        in_valid = v; op_sel = op; op_a = a; op_b = b;
        is_signed = sgn; rnd_en = rnd; sat_en = sat; half_sel = half;
    endtask

    task automatic go(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                      input logic sgn, input logic rnd, input logic sat, input logic half,
                      input string tag);
        step(1'b1, op, a, b, sgn, rnd, sat, half, 1'b0, '0, '0, tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 2'b01, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, '0, '0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "out_valid", 64'(out_valid), 64'h0);
        chk("R11", "acc_out", 64'(acc_out), 64'h0);
        chk("R11", "res_out", 64'(res_out), 64'h0);
        chk("R11", "ovf_sticky", 64'(ovf_sticky), 64'h0);
        rst_n = 1'b1;

        // table of vectors, back to back (R1, R2, R3, R8, R9, R10)
        for (int i = 0; i < NTAB; i++)
            step(1'b1, TAB[i].op, TAB[i].a, TAB[i].b, TAB[i].sgn, TAB[i].rnd,
                 TAB[i].sat, TAB[i].half, 1'b1, TAB[i].e_acc, TAB[i].e_res, "R1_R3_R9");

        // R2: same bit patterns, signed versus unsigned
        go(2'b00, 16'hFFFF, 16'h0002, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        go(2'b00, 16'hFFFF, 16'h0002, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

        // R6: positive saturation with sticky flag
        go(2'b00, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 130; i++)
            go(2'b01, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        go(2'b11, 16'h0, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
        go(2'b11, 16'h0, 16'h0, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        // R4 and R7: idle cycles keep everything
        idle("R4"); idle("R4"); idle("R7");
        go(2'b00, 16'd1, 16'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R7");

        // R5: wrap without saturation, flag untouched
        go(2'b00, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 130; i++)
            go(2'b01, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

        // R6: negative saturation
        go(2'b00, 16'd0, 16'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 130; i++)
            go(2'b10, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
        go(2'b11, 16'h0, 16'h0, 1'b1, 1'b1, 1'b1, 1'b1, "R10");
        go(2'b11, 16'h0, 16'h0, 1'b1, 1'b1, 1'b1, 1'b0, "R8");
        go(2'b01, 16'd2, 16'd3, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
        idle("R4");
        go(2'b00, 16'h1234, 16'hFEDC, 1'b1, 1'b1, 1'b0, 1'b1, "R9");

        repeat (3) idle("R4");
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule